// File: doc/BRIEF.md
# ADC Conversion DMA Sequencer

This block runs ADC conversions and stores each result in external data memory without any processor work. Software loads a 24-bit start pointer through three byte registers, picks one or more trigger sources in a mode register, and sets a DMA enable bit. The block then walks a list in memory. Each two-byte slot first holds a channel number in the upper nibble of its first byte. The block reads that byte, waits for a trigger, converts the channel, and overwrites the slot with the result. An all-ones channel value marks the end of the list.

When it reaches that marker, the block clears its DMA enable and every trigger-mode bit in the same step and pulses a done flag, so no further conversion can start. The ADC analog core is replaced by a request/done handshake that returns a 12-bit result. The memory port is a simple synchronous one: read data arrives one clock after the read strobe, and no bus arbitration is modelled.

Top module: `adc_dma_seq`

## Requirements
- R1: After reset the mode bits, the DMA enable and the pointer are all zero. `adc_req`, `mem_re`, `mem_we` and `seq_done` are low.
- R2: A register write with `cfg_sel` 2, 3 or 4 replaces only pointer bits [7:0], [15:8] or [23:16] respectively. The other two pointer bytes keep their values.
- R3: While DMA is enabled (`cfg_sel` 1, bit 0), the block reads the byte at the pointer with a one-cycle read latency. Bits [7:4] of that byte give the channel, which is driven on `adc_chan`. The value 4'hF is the stop marker.
- R4: Each result is written as two bytes: first {channel, result[11:8]}, then result[7:0]. The pointer increments by one after each byte and wraps from 24'hFFFFFF to 0.
- R5: Mode register (`cfg_sel` 0) bit0 = single start, which clears itself when its conversion starts. Bit1 = continuous. Bit2 = rising edge of `conv_pin`; a held-high pin gives only one trigger. Bit3 = one-cycle `timer_ovf` pulse. A conversion starts only on an enabled trigger.
- R6: A trigger that arrives while a conversion is pending is ignored. Pending means from the start of the conversion until the next channel byte has been read.
- R7: On reading the stop marker, the DMA enable and all four mode bits clear on the next clock, and `seq_done` is high for exactly that one cycle.
- R8: If a register write to the mode or DMA register lands in the cycle in which the stop marker is read, the clearing wins.
- R9: Timer-triggered DMA works from any start address, whichever of the mode and DMA registers is written first.
- R10: `adc_req` stays high, with `adc_chan` stable, until `adc_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 mode, 1 DMA enable, 2/3/4 pointer bytes |
| cfg_wdata | input | 8 | Register write data |
| conv_pin | input | 1 | External conversion-start pin |
| timer_ovf | input | 1 | Timer overflow pulse |
| adc_req | output | 1 | Conversion request to the ADC |
| adc_chan | output | 4 | Channel to convert |
| adc_done | input | 1 | ADC result valid pulse |
| adc_data | input | 12 | ADC result |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_re` |
| mode_o | output | 4 | Current trigger-mode bits |
| dma_en_o | output | 1 | Current DMA enable |
| ptr_o | output | 24 | Current pointer |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two events can meet in a single cycle: the read of the stop marker, and a software write that re-arms a trigger mode. The bench provokes this by watching for the read strobe of a slot that holds the marker. It then drives a continuous-mode write exactly in the following cycle, when the read data is evaluated. It judges the outcome at the ports: the mode bits and the enable must both read zero, `seq_done` must be high for one cycle, and no new conversion request may follow.

// File: rtl/adc_dma_seq.sv
module adc_dma_seq #(
  parameter int ADC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic              conv_pin,
  input  logic              timer_ovf,
  output logic              adc_req,
  output logic [15-ADC_W:0] adc_chan,
  input  logic              adc_done,
  input  logic [ADC_W-1:0]  adc_data,
  output logic              mem_re,
  output logic              mem_we,
  output logic [23:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [3:0]        mode_o,
  output logic              dma_en_o,
  output logic [23:0]       ptr_o,
  output logic              seq_done
);
  localparam int CH_W = 16 - ADC_W;
  localparam int HI_W = ADC_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CHK, S_WAIT, S_CONV, S_WR0, S_WR1} st_t;
  st_t st;

  logic [3:0]       mode, mode_n;
  logic             dma, dma_n;
  logic [23:0]      ptr, ptr_n;
  logic [CH_W-1:0]  chan;
  logic [ADC_W-1:0] res;
  logic             pin_q, done_q;

  wire stop_hit = (st == S_CHK) && (mem_rdata[7:8-CH_W] == {CH_W{1'b1}});
  wire trig     = mode[0] | mode[1] | (mode[2] & conv_pin & ~pin_q) | (mode[3] & timer_ovf);
  wire start    = (st == S_WAIT) && dma && trig;

  always_comb begin
    mode_n = mode;
    dma_n  = dma;
    if (cfg_we && cfg_sel == 3'd0) mode_n = cfg_wdata[3:0];
    if (cfg_we && cfg_sel == 3'd1) dma_n  = cfg_wdata[0];
    if (start && mode[0]) mode_n[0] = 1'b0;
    if (stop_hit) begin
      mode_n = '0;
      dma_n  = 1'b0;
    end
    ptr_n = mem_we ? ptr + 24'd1 : ptr;
    if (cfg_we) begin
      case (cfg_sel)
        3'd2:    ptr_n[7:0]   = cfg_wdata;
        3'd3:    ptr_n[15:8]  = cfg_wdata;
        3'd4:    ptr_n[23:16] = cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode   <= '0;
      dma    <= 1'b0;
      ptr    <= '0;
      chan   <= '0;
      res    <= '0;
      pin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      mode   <= mode_n;
      dma    <= dma_n;
      ptr    <= ptr_n;
      pin_q  <= conv_pin;
      done_q <= stop_hit;
      case (st)
        S_IDLE: if (dma) st <= S_RD;
        S_RD:   st <= S_CHK;
        S_CHK:  if (stop_hit) st <= S_IDLE;
                else begin
                  chan <= mem_rdata[7:8-CH_W];
                  st   <= S_WAIT;
                end
        S_WAIT: if (!dma) st <= S_IDLE;
                else if (start) st <= S_CONV;
        S_CONV: if (adc_done) begin
                  res <= adc_data;
                  st  <= S_WR0;
                end
        S_WR0:  st <= S_WR1;
        S_WR1:  st <= S_RD;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign adc_req   = (st == S_CONV);
  assign adc_chan  = chan;
  assign mem_re    = (st == S_RD);
  assign mem_we    = (st == S_WR0) || (st == S_WR1);
  assign mem_addr  = ptr;
  assign mem_wdata = (st == S_WR0) ? {chan, res[ADC_W-1:ADC_W-HI_W]} : res[7:0];
  assign mode_o    = mode;
  assign dma_en_o  = dma;
  assign ptr_o     = ptr;
  assign seq_done  = done_q;

  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !cfg_we) |=> ptr_o == $past(ptr_o) + 24'd1);
  a_r2_byte_isolation: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 3'd2 && !mem_we) |=> ptr_o[23:8] == $past(ptr_o[23:8]));
  a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (mode_o == 4'd0 && !dma_en_o));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_done) |=> (adc_req && $stable(adc_chan)));
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(adc_req && (mem_we || mem_re)));
endmodule

// File: tb/adc_dma_seq_tb.sv
`timescale 1ns/1ps
module adc_dma_seq_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, conv_pin = 0, timer_ovf = 0;
  logic [2:0] cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic adc_req, adc_done, mem_re, mem_we, dma_en_o, seq_done;
  logic [3:0] adc_chan, mode_o;
  logic [11:0] adc_data;
  logic [23:0] mem_addr, ptr_o;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [256];
  int checks = 0, failures = 0, cnt = 0;

  always #2 clk = ~clk;

  adc_dma_seq u_dut (.clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .conv_pin, .timer_ovf,
    .adc_req, .adc_chan, .adc_done, .adc_data, .mem_re, .mem_we, .mem_addr, .mem_wdata,
    .mem_rdata, .mode_o, .dma_en_o, .ptr_o, .seq_done);

  function automatic logic [11:0] conv(input logic [3:0] c);
    return {c, ~c, c ^ 4'h5};
  endfunction

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  always @(posedge clk) begin
    if (!rst_n) begin adc_done <= 0; adc_data <= 0; cnt <= 0; end
    else if (adc_req && !adc_done) begin
      if (cnt == 4) begin adc_done <= 1; adc_data <= conv(adc_chan); cnt <= 0; end
      else cnt <= cnt + 1;
    end else begin adc_done <= 0; cnt <= 0; end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_ptr(input logic [23:0] a);
    wr(3'd2, a[7:0]); wr(3'd3, a[15:8]); wr(3'd4, a[23:16]);
  endtask

  task automatic wait_done(output logic seen);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (seq_done) seen = 1;
    end
  endtask

  task automatic pulse_timer();
    @(negedge clk); timer_ovf = 1; @(negedge clk); timer_ovf = 0;
  endtask

  // {dma_first, start address, channel, mode}
  localparam logic [35:0] VEC [6] = '{
    {4'h0, 24'h000010, 4'h3, 4'b0001},
    {4'h0, 24'h000020, 4'h7, 4'b0010},
    {4'h0, 24'h000030, 4'h0, 4'b0100},
    {4'h0, 24'h000040, 4'hE, 4'b1000},
    {4'h0, 24'h5A3B50, 4'h9, 4'b1000},
    {4'h1, 24'h001270, 4'hC, 4'b1000}
  };

  task automatic run_vec(input logic [35:0] v);
    logic [23:0] a; logic [3:0] c, m; logic seen; logic [11:0] r;
    a = v[31:8]; c = v[7:4]; m = v[3:0]; r = conv(c);
    mem[a[7:0]] = {c, 4'h0}; mem[a[7:0] + 8'd1] = 8'h00; mem[a[7:0] + 8'd2] = 8'hF0;
    set_ptr(a);
    if (v[32]) begin wr(3'd1, 8'h01); wr(3'd0, {4'h0, m}); end
    else begin wr(3'd0, {4'h0, m}); wr(3'd1, 8'h01); end
    repeat (6) @(negedge clk);
    if (m[2]) begin conv_pin = 1; @(negedge clk); conv_pin = 0; end
    if (m[3]) pulse_timer();
    wait_done(seen);
    check(seen, "R5/R9 sequence completes", {31'd0, seen}, 1);
    check(mem[a[7:0]] == {c, r[11:8]}, "R4 first byte", mem[a[7:0]], {c, r[11:8]});
    check(mem[a[7:0] + 8'd1] == r[7:0], "R4 second byte", mem[a[7:0] + 8'd1], r[7:0]);
    check(ptr_o == a + 24'd2, "R4 pointer advance", ptr_o, a + 24'd2);
    check(mode_o == 0 && !dma_en_o, "R7 bits cleared", {mode_o, dma_en_o}, 0);
  endtask

  initial begin
    logic seen;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(mode_o == 0 && !dma_en_o && ptr_o == 0, "R1 reset regs", {mode_o, dma_en_o, ptr_o}, 0);
    check(!adc_req && !mem_re && !mem_we && !seq_done, "R1 reset outputs",
          {adc_req, mem_re, mem_we, seq_done}, 0);
    rst_n = 1;

    // R2 byte isolation
    set_ptr(24'hC3B2A1);
    check(ptr_o == 24'hC3B2A1, "R2 three bytes", ptr_o, 24'hC3B2A1);
    wr(3'd3, 8'h5A);
    check(ptr_o == 24'hC35AA1, "R2 middle byte only", ptr_o, 24'hC35AA1);
    wr(3'd2, 8'h00);
    check(ptr_o == 24'hC35A00, "R2 low byte only", ptr_o, 24'hC35A00);
    wr(3'd4, 8'h7E);
    check(ptr_o == 24'h7E5A00, "R2 page byte only", ptr_o, 24'h7E5A00);

    for (int i = 0; i < 6; i++) run_vec(VEC[i]);

    // R3/R4 multi-entry continuous list
    mem[8'h80] = 8'h10; mem[8'h82] = 8'h20; mem[8'h84] = 8'h40; mem[8'h86] = 8'hF5;
    set_ptr(24'h000080); wr(3'd0, 8'h02); wr(3'd1, 8'h01);
    wait_done(seen);
    check(seen && ptr_o == 24'h86, "R3 three entries then stop", ptr_o, 24'h86);
    for (int k = 0; k < 3; k++) begin
      logic [3:0] c; logic [11:0] r;
      c = 4'(1 << k); r = conv(c);
      check(mem[8'h80 + 8'(2*k)] == {c, r[11:8]} && mem[8'h81 + 8'(2*k)] == r[7:0],
            "R4 list entry", {mem[8'h80 + 8'(2*k)], mem[8'h81 + 8'(2*k)]}, {c, r[11:8], r[7:0]});
    end

    // R4 wrap at 24 bits
    mem[8'hFF] = 8'h50; mem[8'h01] = 8'hF0;
    set_ptr(24'hFFFFFF); wr(3'd0, 8'h02); wr(3'd1, 8'h01);
    wait_done(seen);
    check(ptr_o == 24'h000001, "R4 wrap pointer", ptr_o, 1);
    check(mem[8'hFF] == 8'h55 && mem[8'h00] == {4'hA, 4'h0}, "R4 wrap bytes",
          {mem[8'hFF], mem[8'h00]}, 16'h55A0);

    // R6 trigger during pending conversion ignored
    mem[8'h60] = 8'h20; mem[8'h62] = 8'h60; mem[8'h64] = 8'hF0;
    set_ptr(24'h000060); wr(3'd0, 8'h08); wr(3'd1, 8'h01);
    repeat (6) @(negedge clk);
    pulse_timer();
    while (!adc_req) @(negedge clk);
    pulse_timer();
    repeat (15) @(negedge clk);
    check(!adc_req && ptr_o == 24'h62 && dma_en_o, "R6 extra trigger ignored",
          {adc_req, dma_en_o, ptr_o}, {2'b01, 24'h62});
    pulse_timer();
    wait_done(seen);
    check(seen && ptr_o == 24'h64 && mem[8'h62] == 8'h66, "R6 next trigger accepted",
          ptr_o, 24'h64);

    // R5 held pin gives one trigger
    mem[8'hA0] = 8'h80; mem[8'hA2] = 8'h90; mem[8'hA4] = 8'hF0;
    set_ptr(24'h0000A0); wr(3'd0, 8'h04); wr(3'd1, 8'h01);
    repeat (6) @(negedge clk);
    conv_pin = 1;
    repeat (25) @(negedge clk);
    check(ptr_o == 24'hA2 && dma_en_o, "R5 held pin single trigger", ptr_o, 24'hA2);
    conv_pin = 0; repeat (2) @(negedge clk); conv_pin = 1;
    wait_done(seen);
    conv_pin = 0;
    check(seen && ptr_o == 24'hA4, "R5 second edge", ptr_o, 24'hA4);

    // R8 write colliding with stop marker
    mem[8'hC0] = 8'hF0;
    set_ptr(24'h0000C0); wr(3'd0, 8'h08); wr(3'd1, 8'h01);
    while (!mem_re) @(negedge clk);
    @(negedge clk); cfg_we = 1; cfg_sel = 3'd0; cfg_wdata = 8'h02;
    @(negedge clk); cfg_we = 0;
    check(mode_o == 0 && !dma_en_o && seq_done, "R8 clear wins",
          {mode_o, dma_en_o, seq_done}, 6'b000001);
    @(negedge clk);
    check(!seq_done, "R7 done one cycle", {31'd0, seq_done}, 0);
    repeat (8) @(negedge clk);
    check(!adc_req && !mem_re && mode_o == 0, "R8 no restart", {adc_req, mem_re, mode_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule